// File: doc/BRIEF.md
# Programmable memory timing pattern sequencer

This block drives the strobes of an external memory from a small array of pattern words. Each memory cycle is split into four quarter-phases. The block steps through one pattern word per memory cycle, and each word gives the levels of four active-low byte-select lines and five general-purpose lines at set phase ticks. The phase counter runs on a clock at four times the memory clock, so every output is a register that changes only on the tick it belongs to.

Software first loads the word array through a synchronous write port. A start request then names a base index, an access address, a transfer size and a read flag. The sequencer runs from the base index, moving to the next index after each word. The index wraps at the end of the array. The run ends after the word whose last bit is set, and all strobes then fall back to their negated level. The byte-select bits of a word only give the timing. The lanes that are actually asserted come from the port size, the transfer size and the two low address bits. One word bit has two meanings. It is the literal level of line 4 when that line is an output. In wait-input mode it selects the edge on which read data is captured.

Top module: `mem_pattern_seq`

## Requirements
- R1: At reset, and on every clock edge taken while idle, `bs_n` becomes 4'hF, `gp_lvl` becomes 5'h1F and `rd_capture` becomes 0.
- R2: `start` is taken at an idle edge E. Word k of the run (k from 0) is read at index (`start_base`+k) mod DEPTH. Its phase 1 tick is edge E+4k+1, its phase 2 tick E+4k+2, its phase 3 tick E+4k+3 and its phase 4 tick E+4k+4. The run ends after the phase 4 tick of the first word whose bit 13 is 1, and the next edge is an idle edge.
- R3: Word bit 0 sets the byte-select lanes at the phase 3 tick, and word bit 1 sets them at the phase 4 tick. A bit value of 0 asserts the enabled lanes and a value of 1 negates all four lanes. `bs_n` does not change at the phase 1 and phase 2 ticks.
- R4: `bs_n[i]` is lane i, and a lane is asserted when its bit is 0. Port size 1 has 2 lanes, port size 2 has 1 lane, and port sizes 0 and 3 have 4 lanes. Transfer size 0 covers 1 byte, size 1 covers 2 bytes, and sizes 2 and 3 cover 4 bytes. The transfer width is limited to the port width. The first lane is (addr[1:0] mod port lanes), rounded down to a multiple of the transfer width.
- R5: `gp_lvl[0]` takes code bits [3:2] at the phase 1 tick and code bits [5:4] at the phase 4 tick. Code 2'b10 drives 0 and codes 2'b11 and 2'b01 drive 1. Code 2'b00 drives bit `g0_bit_sel` of the start address.
- R6: For n = 1, 2 and 3, `gp_lvl[n]` takes word bit 4+2n at the phase 1 tick and word bit 5+2n at the phase 4 tick, with 0 meaning asserted. It does not change at the phase 2 and phase 3 ticks.
- R7: At the phase 1 tick, `gp_lvl[4]` takes word bit 12 when `wait_mode` is 0, and takes 1 when `wait_mode` is 1.
- R8: `rd_capture` is high for one clock only, and only for a read run with `wait_mode` 1. When word bit 12 is 0 it rises after the phase 2 tick. When word bit 12 is 1 it rises after the phase 4 tick.
- R9: A write to the array is stored only at an idle edge. Writes made during a run are ignored.
- R10: A `start` that arrives during a run is ignored, and the run goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four times the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pattern array write strobe |
| wr_idx | input | IDX_W | Index of the word to write |
| wr_data | input | 14 | Pattern word to store |
| start | input | 1 | Request to begin a run |
| start_base | input | IDX_W | First word index of the run |
| start_addr | input | ADDR_W | Access address |
| start_size | input | 2 | Transfer size code |
| start_read | input | 1 | 1 for a read access |
| port_size | input | 2 | Port width code |
| wait_mode | input | 1 | 1 selects the wait-input meaning of bit 12 |
| g0_bit_sel | input | $clog2(ADDR_W) | Address bit used by line 0 code 2'b00 |
| bs_n | output | 4 | Byte-select lanes, active low |
| gp_lvl | output | 5 | General-purpose line levels |
| rd_capture | output | 1 | Read data capture pulse |

## Verification
The hardest cases to reach from the ports are those where the array changes or a second start arrives while a run is in progress, and a run that crosses the top of the array. To reach them, the stimulus sends writes and a second request at chosen offsets inside a run, and it starts a run two words below the top of the array. A model in the bench follows each case, and any later divergence shows up in the outputs. Many runs go through every port size, transfer size, address offset, mode and address-bit selection. In this way both capture edges, all four line 0 codes and a capture pulse on the last tick of a run all occur.

// File: rtl/mps_pkg.sv
package mps_pkg;

  // Pattern word layout; bit 0 is bs_p3.
  typedef struct packed {
    logic       last;       // [13] end of run after this word
    logic       g4_or_edge; // [12] line 4 level / capture edge select
    logic       g3_hi;      // [11]
    logic       g3_lo;      // [10]
    logic       g2_hi;      // [9]
    logic       g2_lo;      // [8]
    logic       g1_hi;      // [7]
    logic       g1_lo;      // [6]
    logic [1:0] g0_hi;      // [5:4]
    logic [1:0] g0_lo;      // [3:2]
    logic       bs_p4;      // [1]
    logic       bs_p3;      // [0]
  } pat_word_t;

  localparam int WORD_W = $bits(pat_word_t);

  // Active-high lane enables from port size, transfer size, low address.
  function automatic logic [3:0] lane_mask(input logic [1:0] psize,
                                           input logic [1:0] tsize,
                                           input logic [1:0] alo);
    logic [1:0] port_m;
    logic [1:0] xfer_m;
    logic [1:0] width_m;
    logic [1:0] offs;
    logic [3:0] base;
    port_m  = (psize == 2'd1) ? 2'b01 : (psize == 2'd2) ? 2'b00 : 2'b11;
    xfer_m  = (tsize == 2'd0) ? 2'b00 : (tsize == 2'd1) ? 2'b01 : 2'b11;
    width_m = xfer_m & port_m;
    offs    = alo & port_m & ~width_m;
    base    = (width_m == 2'b00) ? 4'b0001 :
              (width_m == 2'b01) ? 4'b0011 : 4'b1111;
    return base << offs;
  endfunction

  // Line 0 level from its 2-bit code.
  function automatic logic g0_level(input logic [1:0] code, input logic abit);
    case (code)
      2'b10:   return 1'b0;
      2'b00:   return abit;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/mps_phase_ctl.sv
module mps_phase_ctl #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] base,
  input  logic             last,
  output logic             busy,
  output logic [1:0]       ph,
  output logic [IDX_W-1:0] ptr
);

  logic word_end;
  logic seq_done;
  assign word_end = busy && (ph == 2'd3);
  assign seq_done = word_end && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= 2'd0;
      ptr  <= '0;
    end else if (!busy) begin
      ph <= 2'd0;
      if (start) begin
        busy <= 1'b1;
        ptr  <= base;
      end
    end else begin
      ph <= ph + 2'd1;
      if (seq_done)      busy <= 1'b0;
      else if (word_end) ptr  <= ptr + 1'b1;
    end
  end

  // R2: phases step by one inside a word
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph != 2'd3) |=> (busy && ph == $past(ph) + 2'd1));
  // R2: a word with its last bit set closes the run
  a_r2_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph == 2'd3 && last) |=> !busy);
  // R10: no reload of the index in mid-word, start or not
  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph != 2'd3) |=> $stable(ptr));

endmodule

// File: rtl/mps_pattern_ram.sv
module mps_pattern_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 14,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             busy,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);

  logic [W-1:0] mem [DEPTH];
  logic wr_fire;
  assign wr_fire = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/mps_strobe_gen.sv
module mps_strobe_gen
  import mps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busy,
  input  logic [1:0] ph,
  input  pat_word_t w,
  input  logic [3:0] lanes,
  input  logic      g0_abit,
  input  logic      wait_mode,
  input  logic      rd,
  output logic [3:0] bs_n,
  output logic [4:0] gp_lvl,
  output logic      cap
);

  logic cap_rise;
  logic cap_fall;
  assign cap_rise = wait_mode && rd && !w.g4_or_edge;
  assign cap_fall = wait_mode && rd &&  w.g4_or_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bs_n   <= 4'hF;
      gp_lvl <= 5'h1F;
      cap    <= 1'b0;
    end else if (!busy) begin
      bs_n   <= 4'hF;
      gp_lvl <= 5'h1F;
      cap    <= 1'b0;
    end else begin
      cap <= 1'b0;
      case (ph)
        2'd0: begin
          gp_lvl[0] <= g0_level(w.g0_lo, g0_abit);
          gp_lvl[1] <= w.g1_lo;
          gp_lvl[2] <= w.g2_lo;
          gp_lvl[3] <= w.g3_lo;
          gp_lvl[4] <= wait_mode ? 1'b1 : w.g4_or_edge;
        end
        2'd1: cap <= cap_rise;
        2'd2: bs_n <= w.bs_p3 ? 4'hF : ~lanes;
        default: begin
          bs_n      <= w.bs_p4 ? 4'hF : ~lanes;
          gp_lvl[0] <= g0_level(w.g0_hi, g0_abit);
          gp_lvl[1] <= w.g1_hi;
          gp_lvl[2] <= w.g2_hi;
          gp_lvl[3] <= w.g3_hi;
          cap       <= cap_fall;
        end
      endcase
    end
  end

  a_r1_idle_negated: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (bs_n == 4'hF && gp_lvl == 5'h1F && !cap));
  a_r3_bs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (ph == 2'd0 || ph == 2'd1)) |=> $stable(bs_n));
  a_r6_gp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (ph == 2'd1 || ph == 2'd2)) |=> $stable(gp_lvl[3:1]));
  a_r7_wait_line4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph == 2'd0 && wait_mode) |=> gp_lvl[4]);
  a_r8_cap_single: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !cap);

endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq
  import mps_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEL_W = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_base,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        start_size,
  input  logic              start_read,
  input  logic [1:0]        port_size,
  input  logic              wait_mode,
  input  logic [SEL_W-1:0]  g0_bit_sel,
  output logic [3:0]        bs_n,
  output logic [4:0]        gp_lvl,
  output logic              rd_capture
);

  logic              busy;
  logic [1:0]        ph;
  logic [IDX_W-1:0]  ptr;
  logic [WORD_W-1:0] rd_word;
  pat_word_t         cur;
  logic              seq_accept;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              read_q;
  logic [3:0]        lanes;

  assign seq_accept = start && !busy;
  assign cur        = pat_word_t'(rd_word);
  assign lanes      = lane_mask(port_size, size_q, addr_q[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= 2'd0;
      read_q <= 1'b0;
    end else if (seq_accept) begin
      addr_q <= start_addr;
      size_q <= start_size;
      read_q <= start_read;
    end
  end

  mps_phase_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .base(start_base),
    .last(cur.last), .busy(busy), .ph(ph), .ptr(ptr)
  );

  mps_pattern_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .clk(clk), .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(ptr), .rd_data(rd_word)
  );

  mps_strobe_gen u_gen (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ph(ph), .w(cur),
    .lanes(lanes), .g0_abit(addr_q[g0_bit_sel]), .wait_mode(wait_mode),
    .rd(read_q), .bs_n(bs_n), .gp_lvl(gp_lvl), .cap(rd_capture)
  );

  // R2: an accepted start brings the first word within one edge
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept |=> (busy && ph == 2'd0));

endmodule

// File: tb/mem_pattern_seq_test.sv
`timescale 1ns/1ps
module mem_pattern_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [13:0] wr_data = '0;
  logic        start = 1'b0;
  logic [5:0]  start_base = '0;
  logic [31:0] start_addr = '0;
  logic [1:0]  start_size = '0;
  logic        start_read = 1'b0;
  logic [1:0]  port_size = '0;
  logic        wait_mode = 1'b0;
  logic [4:0]  g0_bit_sel = '0;
  logic [3:0]  bs_n;
  logic [4:0]  gp_lvl;
  logic        rd_capture;

  always #2 clk = ~clk;

  mem_pattern_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .start(start), .start_base(start_base),
    .start_addr(start_addr), .start_size(start_size),
    .start_read(start_read), .port_size(port_size),
    .wait_mode(wait_mode), .g0_bit_sel(g0_bit_sel), .bs_n(bs_n),
    .gp_lvl(gp_lvl), .rd_capture(rd_capture)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string focus = "R1";

  // reference model state
  logic [13:0] m_mem [64];
  int m_busy = 0;
  int m_ph = 0;
  int m_ptr = 0;
  int wb;
  logic [31:0] m_addr;
  int m_sz;
  int m_rd;
  logic [13:0] w;
  logic [3:0] exp_bs = 4'hF;
  logic [4:0] exp_gp = 5'h1F;
  logic exp_cap = 1'b0;

  function automatic logic [3:0] model_lanes(int ps, int sz, logic [31:0] a);
    int pbytes;
    int nb;
    int first;
    logic [3:0] m;
    pbytes = (ps == 1) ? 2 : (ps == 2) ? 1 : 4;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (nb > pbytes) nb = pbytes;
    first = (int'(a[1:0]) % pbytes) / nb * nb;
    m = 4'b0000;
    for (int i = 0; i < 4; i++) if (i >= first && i < first + nb) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic model_g0(logic [1:0] code, logic [31:0] a, int sel);
    if (code == 2'b10) return 1'b0;
    if (code == 2'b00) return a[sel];
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ph = 0; m_ptr = 0;
      exp_bs = 4'hF; exp_gp = 5'h1F; exp_cap = 1'b0;
    end else begin
      wb = m_busy;
      if (wr_en && wb == 0) m_mem[wr_idx] = wr_data;   // R9
      if (wb == 0) begin
        exp_bs = 4'hF; exp_gp = 5'h1F; exp_cap = 1'b0;
        if (start) begin
          m_busy = 1; m_ph = 0; m_ptr = int'(start_base);
          m_addr = start_addr; m_sz = int'(start_size); m_rd = int'(start_read);
        end
      end else begin
        w = m_mem[m_ptr];
        exp_cap = 1'b0;
        if (m_ph == 0) begin
          exp_gp[0] = model_g0(w[3:2], m_addr, int'(g0_bit_sel));
          exp_gp[1] = w[6]; exp_gp[2] = w[8]; exp_gp[3] = w[10];
          exp_gp[4] = wait_mode ? 1'b1 : w[12];
        end else if (m_ph == 1) begin
          exp_cap = wait_mode && m_rd != 0 && !w[12];
        end else if (m_ph == 2) begin
          exp_bs = w[0] ? 4'hF : ~model_lanes(int'(port_size), m_sz, m_addr);
        end else begin
          exp_bs = w[1] ? 4'hF : ~model_lanes(int'(port_size), m_sz, m_addr);
          exp_gp[0] = model_g0(w[5:4], m_addr, int'(g0_bit_sel));
          exp_gp[1] = w[7]; exp_gp[2] = w[9]; exp_gp[3] = w[11];
          exp_cap = wait_mode && m_rd != 0 && w[12];
        end
        if (m_ph == 3) begin
          if (w[13]) m_busy = 0;
          else m_ptr = (m_ptr + 1) % 64;
        end
        m_ph = (m_ph + 1) % 4;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (bs_n !== exp_bs) begin
        fails++;
        $display("FAIL %s R3/R4 bs_n actual %b expected %b", focus, bs_n, exp_bs);
      end
      checks++;
      if (gp_lvl !== exp_gp) begin
        fails++;
        $display("FAIL %s R5/R6/R7 gp_lvl actual %b expected %b", focus, gp_lvl, exp_gp);
      end
      checks++;
      if (rd_capture !== exp_cap) begin
        fails++;
        $display("FAIL %s R8 rd_capture actual %b expected %b", focus, rd_capture, exp_cap);
      end
    end
  end

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (m_busy != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run(int base, logic [31:0] addr, int sz, int rd);
    @(negedge clk);
    start = 1'b1; start_base = 6'(base); start_addr = addr;
    start_size = 2'(sz); start_read = rd[0];
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  task automatic write_word(int idx, logic [13:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R2 watchdog expired actual busy expected idle");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                        // R1: reset levels checked each clock
    repeat (4) @(negedge clk);

    focus = "R9";                        // R9: idle writes fill the array
    for (int i = 0; i < 64; i++) begin
      logic [13:0] d;
      d = 14'((i * 40503 + 17) & 32'h1FFF);
      d[13] = (i % 4 == 1);
      write_word(i, d);
    end

    focus = "R2";                        // R2..R8: sweep of modes and sizes
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      port_size  = 2'(k % 4);
      wait_mode  = ((k / 2) % 2) == 1;
      g0_bit_sel = 5'(k % 5);
      run((k * 7) % 64, 32'(k * 13 + 5) ^ 32'hA5, (k / 4) % 4, k % 2);
    end

    focus = "R2";                        // R2: run wraps across the array top
    wait_mode = 1'b1;
    run(62, 32'h3, 2, 1);

    focus = "R10";                       // R10: second start in mid-run
    @(negedge clk);
    start = 1'b1; start_base = 6'd2; start_addr = 32'h1; start_size = 2'd0;
    start_read = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; start_base = 6'd40; start_addr = 32'h2;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    focus = "R9";                        // R9: write into running words ignored
    @(negedge clk);
    wait_mode = 1'b0;
    start = 1'b1; start_base = 6'd6; start_addr = 32'h0; start_size = 2'd2;
    start_read = 1'b0;
    @(negedge clk);
    start = 1'b0;
    wr_en = 1'b1; wr_idx = 6'd7; wr_data = 14'h0A5A;
    repeat (3) @(negedge clk);
    wr_en = 1'b0;
    wait_idle();
    run(6, 32'h0, 2, 0);                 // R9: rerun shows the old word 7

    focus = "R5";                        // R5: address-driven line 0 code
    write_word(20, 14'b10_0000_0000_0000);
    g0_bit_sel = 5'd31;
    run(20, 32'h8000_0000, 1, 0);
    g0_bit_sel = 5'd0;
    run(20, 32'h8000_0000, 1, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule